// File: doc/BRIEF.md
# Real-FFT half-spectrum output sorter

A real-input FFT produces its half-spectrum in a scrambled order. Some of the bins arrive with an index above N/2, so they are the mirror of a wanted bin. This block takes that stream at one complex sample per valid cycle and emits it again at one sample per valid cycle. The output has every bin index in the range [0, N/2] and is in the slot order that a later natural-order memory expects. The lowest slot carries bins 0 and N/2 together: the real part holds bin 0 and the imaginary part holds bin N/2, because both of these bins are purely real.

The block works in two steps. An entry register folds mirrored bins onto their partners by complex conjugation. A chain of delay-exchange cells then permutes slots within each frame of M = N/2 slots. Each cell swaps slot P with slot P+L using a single feedback line of length L and one multiplexer. Every cell takes its schedule from one shared slot counter. The whole pipeline advances only on cycles where `in_valid` is high, so upstream gaps simply stall it. Frames follow each other with no gap between them.

Top module: `rfft_reorder`

## Requirements
- R1: A sample whose input tag t is greater than N/2 leaves with tag N−t and a negated imaginary part. Its real part is unchanged. A sample with t ≤ N/2 keeps its tag and both of its parts.
- R2: The combined slot has tag 0, with bin 0 in the real part and bin N/2 in the imaginary part. It passes with both parts untouched, and it always lands in output slot 0.
- R3: Slots 0 to 3 of a frame leave in the same slot they entered.
- R4: Consider slot S ≥ 4, with p = floor(log2 S) and offset q = S − 2^p. Form d from q by moving bit 0 of q up to bit p−1 and shifting bits p−1..1 of q down by one place. If bit p−1 of d is clear, the sample leaves in slot 2^p + d.
- R5: If bit p−1 of that d is set, bits p−2..0 of d are also inverted. This reverses the order of the upper half of each group. The sample leaves in slot 2^p + d with the inverted bits.
- R6: The latency is 1 + 2·(N/8 − 1) valid cycles, which is 7 for N = 32. `out_valid` stays low for that many accepted inputs after reset. After that, each accepted input emits exactly one output.
- R7: On a cycle with `in_valid` low, `out_valid` is low and no internal state moves, including the slot counter.
- R8: Slot 0 of the next frame follows slot M−1 of the current frame directly. The slot counter steps by one for each accepted input and wraps modulo M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample present; advances the pipeline |
| in_tag | input | LOG2N | Bin index of the input sample, 0..N−1 |
| in_re | input | W | Real part, two's complement |
| in_im | input | W | Imaginary part, two's complement |
| out_valid | output | 1 | Output sample present |
| out_tag | output | LOG2N | Bin index of the output sample, 0..N/2 |
| out_re | output | W | Real part of the output |
| out_im | output | W | Imaginary part of the output |

## Verification
A cell whose multiplexer fires in the wrong slot puts a wrong or duplicated tag into one particular output slot. This shows up within one frame plus the cell's line length, so tagging each slot with a distinct label and value exposes it at once. A slot counter that drifts during input gaps shifts every later frame by one slot, and the frame that contains the gaps reveals it. A wrong conjugation shows up as a tag above N/2 or as a sign-flipped imaginary part on the affected slot.

// File: rtl/rfr_pkg.sv
package rfr_pkg;

  // Line length of cell k: deinterleave cells come first, then reversal cells.
  function automatic int cell_len(input int k, input int half);
    return 1 << (k % half);
  endfunction

  // Valid-cycle distance from the block input to the input of cell k.
  function automatic int cell_off(input int k, input int half);
    int s;
    s = 1;
    for (int i = 0; i < k; i++) s += cell_len(i, half);
    return s;
  endfunction

  // High in the slot whose sample bypasses the line (the P+L member of a pair).
  // b is the lower bit of the pair being handled; rev selects a reversal cell.
  function automatic logic swap_slot(input logic [31:0] pos, input int b, input logic rev);
    int p;
    p = 0;
    for (int i = 0; i < 32; i++) if (pos[i]) p = i;
    if (pos < 4 || p < b + 2) return 1'b0;
    if (rev) return pos[p-1] & pos[b];
    return ~pos[b] & pos[b+1];
  endfunction

endpackage

// File: rtl/rfr_conj.sv
module rfr_conj #(
  parameter int N  = 32,
  parameter int W  = 16,
  parameter int TW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [TW-1:0]     tag,
  input  logic [W-1:0]      re,
  input  logic [W-1:0]      im,
  output logic [TW+2*W-1:0] q
);
  logic          mirror;
  logic [TW-1:0] ntag;
  logic [W-1:0]  nim;

  always_comb begin
    mirror = (tag > TW'(N / 2));
    ntag   = mirror ? (TW'(0) - tag) : tag;  // N - tag modulo 2^TW
    nim    = mirror ? (W'(0) - im) : im;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (adv) q <= {ntag, re, nim};
  end
endmodule

// File: rtl/rfr_swap_cell.sv
module rfr_swap_cell #(
  parameter int SW = 37,
  parameter int L  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          bypass,
  input  logic [SW-1:0] d,
  output logic [SW-1:0] q
);
  logic [SW-1:0] line [L];
  logic [SW-1:0] line_out;
  logic [SW-1:0] feed;

  always_comb begin
    line_out = line[L-1];
    feed     = bypass ? line_out : d;  // recirculate the held sample
    q        = bypass ? d : line_out;  // late sample jumps ahead
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < L; i++) line[i] <= '0;
    end else if (adv) begin
      line[0] <= feed;
      for (int i = 1; i < L; i++) line[i] <= line[i-1];
    end
  end
endmodule

// File: rtl/rfft_reorder.sv
module rfft_reorder #(
  parameter int LOG2N = 5,
  parameter int W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [LOG2N-1:0] in_tag,
  input  logic [W-1:0]     in_re,
  input  logic [W-1:0]     in_im,
  output logic             out_valid,
  output logic [LOG2N-1:0] out_tag,
  output logic [W-1:0]     out_re,
  output logic [W-1:0]     out_im
);
  localparam int N    = 1 << LOG2N;
  localparam int MW   = LOG2N - 1;
  localparam int TW   = LOG2N;
  localparam int SW   = TW + 2 * W;
  localparam int HALF = LOG2N - 3;
  localparam int NC   = 2 * HALF;
  localparam int LAT  = rfr_pkg::cell_off(NC, HALF);
  localparam int LW   = $clog2(LAT + 1);

  logic [MW-1:0] in_pos;
  logic [LW-1:0] fill;
  logic [NC-1:0] swap_sel;
  logic [SW-1:0] stage [NC+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pos <= '0;
      fill   <= '0;
    end else if (in_valid) begin
      in_pos <= in_pos + MW'(1);
      if (fill != LW'(LAT)) fill <= fill + LW'(1);
    end
  end

  rfr_conj #(.N(N), .W(W), .TW(TW)) u_conj (
    .clk(clk), .rst_n(rst_n), .adv(in_valid),
    .tag(in_tag), .re(in_re), .im(in_im), .q(stage[0])
  );

  for (genvar k = 0; k < NC; k++) begin : g_cell
    localparam int CL  = rfr_pkg::cell_len(k, HALF);
    localparam int OFF = rfr_pkg::cell_off(k, HALF);
    logic [MW-1:0] cpos;
    assign cpos = in_pos - MW'(OFF);
    assign swap_sel[k] = rfr_pkg::swap_slot({{(32-MW){1'b0}}, cpos}, k % HALF, k >= HALF);

    rfr_swap_cell #(.SW(SW), .L(CL)) u_cell (
      .clk(clk), .rst_n(rst_n), .adv(in_valid), .bypass(swap_sel[k]),
      .d(stage[k]), .q(stage[k+1])
    );
  end

  assign out_valid = in_valid && (fill == LW'(LAT));
  assign out_tag   = stage[NC][SW-1 -: TW];
  assign out_re    = stage[NC][2*W-1 -: W];
  assign out_im    = stage[NC][W-1:0];
endmodule

// File: rtl/rfft_reorder_chk.sv
module rfft_reorder_chk #(
  parameter int LOG2N = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [LOG2N-1:0] out_tag,
  input logic [LOG2N-2:0] frame_pos
);
  localparam int N  = 1 << LOG2N;
  localparam int MW = LOG2N - 1;
  localparam int D  = 1 + 2 * (N / 8 - 1);

  int seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 0;
    else if (in_valid && seen < D) seen <= seen + 1;
  end

  a_r6_no_early_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seen >= D));

  a_r7_idle_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !out_valid);

  a_r7_idle_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(frame_pos));

  a_r8_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (frame_pos == MW'($past(frame_pos) + MW'(1))));

  a_r1_tag_folded: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_tag <= LOG2N'(N / 2)));
endmodule

bind rfft_reorder rfft_reorder_chk #(.LOG2N(LOG2N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_tag(out_tag), .frame_pos(in_pos)
);

// File: tb/rfft_reorder_bench.sv
module rfft_reorder_bench;
  localparam int PERIOD = 10;
  localparam int LOG2N  = 5;
  localparam int W      = 16;
  localparam int N      = 1 << LOG2N;
  localparam int M      = N / 2;
  localparam int NF     = 4;
  localparam int NCHK   = 3 * M;
  localparam int LATE   = 1 + 2 * (N / 8 - 1);

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [LOG2N-1:0] in_tag = '0;
  logic [W-1:0] in_re = '0, in_im = '0;
  logic out_valid;
  logic [LOG2N-1:0] out_tag;
  logic [W-1:0] out_re, out_im;

  always #(PERIOD/2) clk = ~clk;

  rfft_reorder #(.LOG2N(LOG2N), .W(W)) u_rfft_reorder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_tag(out_tag),
    .out_re(out_re), .out_im(out_im)
  );

  int total = 0, bad = 0, nout = 0, early = 0, run = 0, done = 0;
  int dst [M];
  int src [M];
  logic [LOG2N-1:0] st [NF*M];
  logic [W-1:0] sr [NF*M], si [NF*M];
  logic [LOG2N-1:0] et [NF*M];
  logic [W-1:0] er [NF*M], ei [NF*M];

  function automatic int target(input int s);
    int p, q, h, d;
    if (s < 4) return s;
    p = 0;
    while ((2 << p) <= s) p++;
    q = s - (1 << p);
    h = 1 << (p - 1);
    d = (q % 2) * h + q / 2;
    if (d >= h) d = h + (h - 1 - (d - h));
    return (1 << p) + d;
  endfunction

  function automatic int brev(input int j);
    int r;
    r = 0;
    for (int b = 0; b < LOG2N - 1; b++) if (j & (1 << b)) r |= 1 << (LOG2N - 2 - b);
    return r;
  endfunction

  function automatic string req_of(input int f, input int j, input int t);
    int p;
    if (f == 1 && t != 0) return "R1";
    if (j == 0) return "R2";
    if (j < 4) return "R3";
    if (f == 2) return "R8";
    p = 0;
    while ((2 << p) <= j) p++;
    if (j >= (1 << p) + (1 << (p - 1))) return "R5";
    return "R4";
  endfunction

  always @(negedge clk) begin
    if (run == 1) begin
      if (in_valid && !out_valid && nout == 0) early++;
      if (!in_valid) begin
        total++;
        if (out_valid) begin
          bad++;
          $display("FAIL R7 idle cycle: out_valid=%0b expected 0", out_valid);
        end
      end
      if (out_valid) begin
        if (nout < NCHK) begin
          total++;
          if (out_tag !== et[nout] || out_re !== er[nout] || out_im !== ei[nout]) begin
            bad++;
            $display("FAIL %s slot %0d frame %0d: got tag=%0d re=%0d im=%0d expected tag=%0d re=%0d im=%0d",
                     req_of(nout / M, nout % M, int'(et[nout])), nout % M, nout / M,
                     out_tag, $signed(out_re), $signed(out_im),
                     et[nout], $signed(er[nout]), $signed(ei[nout]));
          end
        end
        nout++;
      end
    end
  end

  initial begin
    #(PERIOD * 5000);
    if (done == 0) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < M; s++) begin
      dst[s] = target(s);
      src[dst[s]] = s;
    end
    for (int f = 0; f < NF; f++) begin
      for (int j = 0; j < M; j++) begin
        int t, re, im, flip, s;
        t = brev(j);
        re = f * 100 + j * 3 + 1;
        im = j * 5 - 20 + f;
        flip = (t != 0) && ((f == 1) || (f == 2 && (j % 2 == 1)));
        et[f*M+j] = LOG2N'(t);
        er[f*M+j] = W'(re);
        ei[f*M+j] = W'(im);
        s = f * M + src[j];
        st[s] = flip ? LOG2N'(N - t) : LOG2N'(t);
        sr[s] = W'(re);
        si[s] = flip ? W'(-im) : W'(im);
      end
    end

    in_valid = 1;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R6 reset: out_valid=%0b expected 0", out_valid);
    end
    in_valid = 0;
    rst_n = 1;
    run = 1;
    for (int i = 0; i < NF * M; i++) begin
      if (i >= 2 * M && i < 3 * M && (i % 3) == 2) begin
        in_valid = 0;
        @(posedge clk); #1;
      end
      in_valid = 1;
      in_tag = st[i];
      in_re = sr[i];
      in_im = si[i];
      @(posedge clk); #1;
    end
    in_valid = 0;
    repeat (4) @(posedge clk);
    #1;
    total++;
    if (early != LATE) begin
      bad++;
      $display("FAIL R6 latency: inputs before first output=%0d expected %0d", early, LATE);
    end
    total++;
    if (nout != NF * M - LATE) begin
      bad++;
      $display("FAIL R8 output count: got %0d expected %0d", nout, NF * M - LATE);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule